// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the chip's internal reset from three inputs. The first is a supply-good level from an analog power monitor. The second is a clock-valid level from the oscillator qualification logic. The third is the external reset pin. Whenever the supply is not good, the internal reset is driven high at once, without waiting for a clock edge. Once the supply is good, the reset is held for a fixed delay and then released. That delay is counted in clock periods, and only while the clock is marked valid.

The external pin does not act directly. A short spike on it is rejected, and reset is forced only when the pin stays high for two machine cycles of clocks. The machine cycle is 12 clocks in standard mode and 6 clocks in double-speed mode. When the pin drops again, the internal reset is released almost at once, without repeating the power-up delay. Reset assertion is asynchronous and release is synchronous. The supply-good level passes through a two-flop synchronizer before the delay counter may start.

Top module: `por_sequencer`

## Requirements
- R1: While `supplyGood` is low, `rstOut` is high. It goes high within the same time step as the fall of `supplyGood`, with no clock edge between them.
- R2: `supplyGood` may rise while `clkValid` is already high. In that case `rstOut` falls at the rising clock edge numbered DELAY_CYCLES+3 after the rise, where the first rising edge after the rise is numbered 1. The default DELAY_CYCLES is 1024.
- R3: The delay counter advances only on edges where `clkValid` is high. A low `clkValid` before release clears the count. Take `supplyGood` as already synchronized, and number the edges from the last rise of `clkValid`. `rstOut` then falls at rising edge DELAY_CYCLES+1.
- R4: A fall of `supplyGood` clears the delay counter. Every recovery therefore waits the full delay of R2.
- R5: Suppose `rstPin` is sampled high on N consecutive rising edges. N is 24 when `dblSpeed` is 0 and 12 when `dblSpeed` is 1. Then `rstOut` rises at edge N+1 and stays high while the pin stays high.
- R6: A single low sample of `rstPin` restarts its high count. A pin pulse of N-1 or fewer high samples leaves `rstOut` low.
- R7: After a pin-initiated reset, `rstPin` may go low once the delay of R2 has finished. `rstOut` then falls at the second rising edge after that, with no further DELAY_CYCLES wait.
- R8: Once reset has been released, `clkValid` going low has no effect on `rstOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| supplyGood | input | 1 | Supply-good level from the power monitor; low forces reset asynchronously |
| clkValid | input | 1 | Oscillator is stable; gates the release delay counter |
| rstPin | input | 1 | External reset pin, active high, filtered |
| dblSpeed | input | 1 | 1 selects the 6-clock machine cycle, 0 the 12-clock one |
| rstOut | output | 1 | Internal reset, active high |

## Verification
The release delay is timed from two different starting points. One is a supply rise with the clock already valid, which includes the two synchronizer edges. The other is a late clock-valid rise on a settled supply. Both are measured to the exact edge, and a one-cycle dropout of `clkValid` shows whether the count restarts or only pauses. A supply loss in the middle of a count checks that the reset asserts between clock edges and that the full wait begins again. The pin filter is driven with three patterns: an exact-length high run in both speed modes, a run one sample short, and two runs split by a single low sample. Together these separate a correct consecutive-run count from an off-by-one limit or from a count that only accumulates.

// File: rtl/por_pkg.sv
package por_pkg;

  // Strobes the sequencing control sends to the counting datapath.
  typedef struct packed {
    logic delayStep;   // advance the release delay counter
    logic delayClear;  // return the release delay counter to zero
  } seqStrobe_t;

endpackage

// File: rtl/por_datapath.sv
module por_datapath
  import por_pkg::*;
#(
  parameter int DELAY_CYCLES = 1024,
  parameter int STD_MC       = 12,
  parameter int DBL_MC       = 6,
  parameter int PIN_MC       = 2
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  seqStrobe_t strobe,
  input  logic       rstPin,
  input  logic       dblSpeed,
  output logic       delayLast,
  output logic       pinHeld
);

  localparam int DW      = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam int STD_LIM = STD_MC * PIN_MC;
  localparam int DBL_LIM = DBL_MC * PIN_MC;
  localparam int MAX_LIM = (STD_LIM > DBL_LIM) ? STD_LIM : DBL_LIM;
  localparam int PW      = $clog2(MAX_LIM + 1);

  logic [DW-1:0] delayCnt;
  logic [PW-1:0] pinCnt;
  logic [PW-1:0] pinLim;

  // Release delay counter, cleared asynchronously by supply loss.
  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)            delayCnt <= '0;
    else if (strobe.delayClear) delayCnt <= '0;
    else if (strobe.delayStep)  delayCnt <= delayCnt + 1'b1;
  end

  assign delayLast = (delayCnt == DW'(DELAY_CYCLES - 1));

  // Pin filter: consecutive high samples, saturating at the mode limit.
  assign pinLim = dblSpeed ? PW'(DBL_LIM) : PW'(STD_LIM);

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)          pinCnt <= '0;
    else if (!rstPin)         pinCnt <= '0;
    else if (pinCnt < pinLim) pinCnt <= pinCnt + 1'b1;
  end

  assign pinHeld = (pinCnt >= pinLim);

endmodule

// File: rtl/por_control.sv
module por_control
  import por_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       clkValid,
  input  logic       delayLast,
  input  logic       pinHeld,
  output seqStrobe_t strobe,
  output logic       rstOut
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   supplySync;
  logic                   released;

  // Synchronizer: asynchronous clear, synchronous release.
  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) syncChain[0] <= 1'b0;
    else             syncChain[0] <= 1'b1;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge supplyGood) begin
      if (!supplyGood) syncChain[s] <= 1'b0;
      else             syncChain[s] <= syncChain[s-1];
    end
  end

  assign supplySync = syncChain[SYNC_STAGES-1];

  always_comb begin
    strobe.delayStep  = supplySync && clkValid && !released;
    strobe.delayClear = !supplySync || (!clkValid && !released);
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)                             released <= 1'b0;
    else if (strobe.delayStep && delayLast)      released <= 1'b1;
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) rstOut <= 1'b1;
    else             rstOut <= !released || pinHeld;
  end

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_pkg::*;
#(
  parameter int DELAY_CYCLES = 1024,
  parameter int STD_MC       = 12,
  parameter int DBL_MC       = 6,
  parameter int PIN_MC       = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic supplyGood,
  input  logic clkValid,
  input  logic rstPin,
  input  logic dblSpeed,
  output logic rstOut
);

  seqStrobe_t strobe;
  logic       delayLast;
  logic       pinHeld;

  por_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .supplyGood (supplyGood),
    .clkValid   (clkValid),
    .delayLast  (delayLast),
    .pinHeld    (pinHeld),
    .strobe     (strobe),
    .rstOut     (rstOut)
  );

  por_datapath #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .STD_MC       (STD_MC),
    .DBL_MC       (DBL_MC),
    .PIN_MC       (PIN_MC)
  ) u_dp (
    .clk        (clk),
    .supplyGood (supplyGood),
    .strobe     (strobe),
    .rstPin     (rstPin),
    .dblSpeed   (dblSpeed),
    .delayLast  (delayLast),
    .pinHeld    (pinHeld)
  );

endmodule

// File: rtl/por_checker.sv
module por_checker #(
  parameter int DELAY_CYCLES = 1024,
  parameter int STD_MC       = 12,
  parameter int DBL_MC       = 6,
  parameter int PIN_MC       = 2
) (
  input logic clk,
  input logic supplyGood,
  input logic clkValid,
  input logic rstPin,
  input logic dblSpeed,
  input logic rstOut
);

  localparam int VW = $clog2(DELAY_CYCLES + 2);

  logic [VW-1:0] validRun;
  logic          seenWindow;
  logic [15:0]   pinRun;
  logic [15:0]   pinLim;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      validRun   <= '0;
      seenWindow <= 1'b0;
    end else begin
      if (!clkValid)                                validRun <= '0;
      else if (validRun < VW'(DELAY_CYCLES))        validRun <= validRun + 1'b1;
      if (validRun >= VW'(DELAY_CYCLES))            seenWindow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)            pinRun <= '0;
    else if (!rstPin)           pinRun <= '0;
    else if (pinRun != 16'hFFFF) pinRun <= pinRun + 1'b1;
  end

  assign pinLim = dblSpeed ? 16'(DBL_MC * PIN_MC) : 16'(STD_MC * PIN_MC);

  // R3: release never comes before a full window of valid clocks.
  assert_release_after_window_R3: assert property (@(posedge clk) disable iff (!supplyGood)
    $fell(rstOut) |-> seenWindow);

  // R5: a sustained pin level forces reset on the following edge.
  assert_pin_forces_reset_R5: assert property (@(posedge clk) disable iff (!supplyGood)
    (pinRun >= pinLim) |=> rstOut);

  // R7: a release is never seen with the pin still high.
  assert_release_pin_low_R7: assert property (@(posedge clk) disable iff (!supplyGood)
    $fell(rstOut) |-> !$past(rstPin));

  // R8: once released, with the pin low, reset stays released.
  assert_stay_released_R8: assert property (@(posedge clk) disable iff (!supplyGood)
    (!rstOut && !rstPin) |=> !rstOut);

endmodule

bind por_sequencer por_checker #(
  .DELAY_CYCLES (DELAY_CYCLES),
  .STD_MC       (STD_MC),
  .DBL_MC       (DBL_MC),
  .PIN_MC       (PIN_MC)
) u_chk (
  .clk        (clk),
  .supplyGood (supplyGood),
  .clkValid   (clkValid),
  .rstPin     (rstPin),
  .dblSpeed   (dblSpeed),
  .rstOut     (rstOut)
);

// File: tb/sim_por_sequencer.sv
module sim_por_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 1024;
  localparam int STD_LIM    = 24;
  localparam int DBL_LIM    = 12;

  logic clk = 1'b0;
  logic supplyGood = 1'b0;
  logic clkValid = 1'b0;
  logic rstPin = 1'b0;
  logic dblSpeed = 1'b0;
  logic rstOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  por_sequencer u0 (
    .clk        (clk),
    .supplyGood (supplyGood),
    .clkValid   (clkValid),
    .rstPin     (rstPin),
    .dblSpeed   (dblSpeed),
    .rstOut     (rstOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts rising edges until rstOut reaches lvl, sampling 1 time unit after each edge.
  task automatic edgesUntil(input logic lvl, output int n);
    n = 0;
    while (rstOut !== lvl && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic testResetState();
    repeat (5) @(posedge clk);
    #1;
    check(rstOut === 1'b1, "R1 reset state", int'(rstOut), 1);
  endtask

  task automatic testPowerUp();
    int n;
    @(negedge clk);
    clkValid   = 1'b1;
    supplyGood = 1'b1;
    edgesUntil(1'b0, n);
    check(n == DELAY + 3, "R2 power-up release edge", n, DELAY + 3);
  endtask

  task automatic testLateClock();
    int n;
    @(negedge clk);
    supplyGood = 1'b0;
    clkValid   = 1'b0;
    #1;
    check(rstOut === 1'b1, "R1 async on drop", int'(rstOut), 1);
    @(negedge clk);
    supplyGood = 1'b1;
    repeat (DELAY + 20) @(negedge clk);
    check(rstOut === 1'b1, "R3 held while clock invalid", int'(rstOut), 1);
    clkValid = 1'b1;
    edgesUntil(1'b0, n);
    check(n == DELAY + 1, "R3 release after clock valid", n, DELAY + 1);
  endtask

  task automatic testClockDropout();
    int n;
    @(negedge clk);
    supplyGood = 1'b0;
    clkValid   = 1'b0;
    @(negedge clk);
    supplyGood = 1'b1;
    repeat (4) @(negedge clk);
    clkValid = 1'b1;
    repeat (500) @(negedge clk);
    clkValid = 1'b0;
    @(negedge clk);
    clkValid = 1'b1;
    edgesUntil(1'b0, n);
    check(n == DELAY + 1, "R3 dropout restarts count", n, DELAY + 1);
  endtask

  task automatic testSupplyLoss();
    int n;
    repeat (10) @(negedge clk);
    supplyGood = 1'b0;
    @(negedge clk);
    supplyGood = 1'b1;
    repeat (600) @(negedge clk);
    #2;
    supplyGood = 1'b0;
    #1;
    check(rstOut === 1'b1, "R1 async mid-count", int'(rstOut), 1);
    @(negedge clk);
    supplyGood = 1'b1;
    edgesUntil(1'b0, n);
    check(n == DELAY + 3, "R4 full wait after loss", n, DELAY + 3);
  endtask

  task automatic testClockLossAfterRelease();
    int highs = 0;
    @(negedge clk);
    clkValid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (rstOut !== 1'b0) highs++;
    end
    check(highs == 0, "R8 clock loss ignored", highs, 0);
    @(negedge clk);
    clkValid = 1'b1;
  endtask

  task automatic testPinFilter(input logic dbl, input int lim);
    int n;
    @(negedge clk);
    dblSpeed = dbl;
    @(negedge clk);
    rstPin = 1'b1;
    edgesUntil(1'b1, n);
    check(n == lim + 1, dbl ? "R5 pin reset double speed" : "R5 pin reset standard", n, lim + 1);
    repeat (30) @(negedge clk);
    check(rstOut === 1'b1, "R5 held while pin high", int'(rstOut), 1);
    rstPin = 1'b0;
    edgesUntil(1'b0, n);
    check(n == 2, "R7 release after pin low", n, 2);
  endtask

  task automatic testShortPulses();
    int highs = 0;
    @(negedge clk);
    dblSpeed = 1'b0;
    rstPin   = 1'b1;
    repeat (STD_LIM - 1) @(negedge clk);
    rstPin = 1'b0;
    repeat (2) @(negedge clk);
    rstPin = 1'b1;
    repeat (STD_LIM - 4) @(negedge clk);
    rstPin = 1'b0;
    @(negedge clk);
    rstPin = 1'b1;
    repeat (STD_LIM - 4) @(negedge clk);
    rstPin = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      if (rstOut !== 1'b0) highs++;
    end
    check(highs == 0, "R6 short pulses rejected", highs, 0);
    check(rstOut === 1'b0, "R6 final level", int'(rstOut), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testResetState();
    testPowerUp();
    testClockLossAfterRelease();
    testPinFilter(1'b0, STD_LIM);
    testPinFilter(1'b1, DBL_LIM);
    testShortPulses();
    testLateClock();
    testClockDropout();
    testSupplyLoss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule